// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is a single timer channel that advances on a tick supplied by a shared prescaler. It keeps a count, a reload value and a small control/status word. While the channel is running, each tick lowers the count by one. The channel expires on the tick that finds the count already at zero, when the count would pass below zero. So a count of N lasts N+1 ticks.

On expiry the channel can raise a one-cycle interrupt pulse and latch a sticky pending flag. With auto-restart set, it reloads and keeps running. Without it, the channel switches itself off. Software-side logic drives three write strobes that share one data bus: one for the count, one for the reload value and one for the control word. The current count, reload value and control word are always visible on read-back outputs. Address decoding and the prescaler sit outside the block.

Top module: `tmr_channel`

## Requirements
- R1: The control word uses these bits: bit 0 run enable, bit 1 auto-restart, bit 2 load command, bit 3 interrupt enable, bit 4 pending flag, bit 5 chain and bit 6 halt. `ctl_o` returns the stored bits in those same positions.
- R2: While run enable is 1 and no count is written in that cycle, each cycle with `tick_i` high lowers the count by one. Without a tick, or with run enable at 0, the count holds.
- R3: Expiry occurs on a tick that finds the count at zero while run enable is 1. A count of N therefore expires on the (N+1)th tick.
- R4: On an expiry with interrupt enable set, the pending flag becomes 1. `irq_o` is high for exactly the cycle after the expiring tick's clock edge.
- R5: On an expiry with auto-restart set, the count takes the reload value and running continues. Without auto-restart, run enable drops to 0 and the count stays at zero.
- R6: A control write with bit 4 set clears the pending flag. A control write with bit 4 clear leaves the flag unchanged.
- R7: If a pending-setting expiry and a pending-clearing control write happen in the same cycle, the flag ends up set.
- R8: A control write with bit 2 set copies the reload value into the count, and counting proceeds from it if run enable is written as 1. Bit 2 always reads back as 0.
- R9: A count write replaces the count with the data. It overrides any tick or expiry in that cycle, and counting continues from the new value if running.
- R10: Bits 5 and 6 are stored and read back but change no counting or interrupt behaviour.
- R11: After reset, the count, reload value and control word are zero and `irq_o` is low.
- R12: A reload write stores the data and does not change the count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick, one count step |
| cnt_wr_i | input | 1 | Write strobe for the count |
| rld_wr_i | input | 1 | Write strobe for the reload value |
| ctl_wr_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | CNT_W | Shared write data |
| cnt_o | output | CNT_W | Current count |
| rld_o | output | CNT_W | Current reload value |
| ctl_o | output | 7 | Control/status read-back |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The embedded properties assume that at most one of the three write strobes is high in any cycle. This is how a register decoder drives them, and one property checks it on the inputs. Ticks are not restricted: they may land on any cycle, including cycles that carry a write. Both the directed sequences and the random phase raise a single strobe per cycle at most, while ticks are placed freely, and some deliberately coincide with count writes and pending-clearing control writes at zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CTL_W = 7;
    localparam int EN_B  = 0;
    localparam int AR_B  = 1;
    localparam int LD_B  = 2;
    localparam int IE_B  = 3;
    localparam int IP_B  = 4;
    localparam int CH_B  = 5;
    localparam int DH_B  = 6;

    typedef struct packed {
        logic en;
        logic ar;
        logic ie;
        logic ip;
        logic ch;
        logic dh;
        logic irq;
    } ctl_st_t;
endpackage

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         auto_rl_i,
    input  logic         cnt_wr_i,
    input  logic         rld_wr_i,
    input  logic         load_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         expire_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    step;
    logic    at_zero;

    assign at_zero  = (s_q.cnt == '0);
    assign step     = tick_i && run_i && !cnt_wr_i && !load_i;
    assign expire_o = step && at_zero;

    always_comb begin
        s_d = s_q;
        if (rld_wr_i) s_d.rld = wr_data_i;
        if (load_i) begin
            s_d.cnt = s_q.rld;
        end else if (cnt_wr_i) begin
            s_d.cnt = wr_data_i;
        end else if (step) begin
            if (at_zero) s_d.cnt = auto_rl_i ? s_q.rld : '0;
            else         s_d.cnt = s_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign rld_o = s_q.rld;

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !at_zero && !cnt_wr_i && !load_i) |=> cnt_o == $past(cnt_o) - W'(1));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_i && run_i) && !cnt_wr_i && !load_i) |=> $stable(cnt_o));
    // R5
    restart_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && auto_rl_i) |=> cnt_o == $past(rld_o));
    // R9
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> cnt_o == $past(wr_data_i));
endmodule

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] wr_bits_i,
    input  logic             expire_i,
    output logic             en_o,
    output logic             ar_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             irq_o
);
    ctl_st_t s_d, s_q;
    logic    fire;

    assign fire = expire_i && s_q.ie;

    always_comb begin
        s_d     = s_q;
        s_d.irq = fire;
        if (ctl_wr_i) begin
            s_d.en = wr_bits_i[EN_B];
            s_d.ar = wr_bits_i[AR_B];
            s_d.ie = wr_bits_i[IE_B];
            s_d.ch = wr_bits_i[CH_B];
            s_d.dh = wr_bits_i[DH_B];
            if (wr_bits_i[IP_B]) s_d.ip = 1'b0;
        end else if (expire_i && !s_q.ar) begin
            s_d.en = 1'b0;
        end
        if (fire) s_d.ip = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctl_o       = '0;
        ctl_o[EN_B] = s_q.en;
        ctl_o[AR_B] = s_q.ar;
        ctl_o[IE_B] = s_q.ie;
        ctl_o[IP_B] = s_q.ip;
        ctl_o[CH_B] = s_q.ch;
        ctl_o[DH_B] = s_q.dh;
    end

    assign en_o  = s_q.en;
    assign ar_o  = s_q.ar;
    assign irq_o = s_q.irq;

    // R4
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl_o[IP_B]);
    // R6
    pend_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_o[IP_B]) |-> $past(ctl_wr_i && wr_bits_i[IP_B]));
    // R5
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !ar_o && !ctl_wr_i) |=> !en_o);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && s_q.ie) |=> ctl_o[IP_B] && irq_o);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic             rld_wr_i,
    input  logic             ctl_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             irq_o
);
    logic run, auto_rl, expire, load_cmd;

    assign load_cmd = ctl_wr_i && wr_data_i[LD_B];

    tmr_downcount #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (run),
        .auto_rl_i (auto_rl),
        .cnt_wr_i  (cnt_wr_i),
        .rld_wr_i  (rld_wr_i),
        .load_i    (load_cmd),
        .wr_data_i (wr_data_i),
        .cnt_o     (cnt_o),
        .rld_o     (rld_o),
        .expire_o  (expire)
    );

    tmr_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr_i  (ctl_wr_i),
        .wr_bits_i (wr_data_i[CTL_W-1:0]),
        .expire_i  (expire),
        .en_o      (run),
        .ar_o      (auto_rl),
        .ctl_o     (ctl_o),
        .irq_o     (irq_o)
    );

    // R9 input rule: one write strobe per cycle at most
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_wr_i, rld_wr_i, ctl_wr_i}));
    // R8
    load_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd |=> (cnt_o == $past(rld_o)) && !ctl_o[LD_B]);
endmodule

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cw = 1'b0, rw = 1'b0, kw = 1'b0;
    logic [31:0] d = '0;
    logic [31:0] cnt, rld;
    logic [6:0]  ctl;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr_channel #(.CNT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_wr_i(kw), .rld_wr_i(rw),
        .ctl_wr_i(cw), .wr_data_i(d), .cnt_o(cnt), .rld_o(rld), .ctl_o(ctl), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference
    logic [31:0] m_cnt, m_rld;
    bit m_en, m_ar, m_ie, m_ip, m_ch, m_dh, m_irq;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_en = 0; m_ar = 0; m_ie = 0;
            m_ip = 0; m_ch = 0; m_dh = 0; m_irq = 0;
        end else begin
            bit ld, ex, n_en, n_ip;
            logic [31:0] n_cnt;
            ld = cw && d[2];
            ex = tick && m_en && (m_cnt == 0) && !kw && !ld;
            n_cnt = m_cnt;
            if (ld) n_cnt = m_rld;
            else if (kw) n_cnt = d;
            else if (tick && m_en) n_cnt = (m_cnt == 0) ? (m_ar ? m_rld : 32'd0) : m_cnt - 1;
            n_en = m_en;
            if (cw) n_en = d[0];
            else if (ex && !m_ar) n_en = 0;
            n_ip = m_ip;
            if (cw && d[4]) n_ip = 0;
            if (ex && m_ie) n_ip = 1;
            m_irq = ex && m_ie;
            if (rw) m_rld = d;
            if (cw) begin m_ar = d[1]; m_ie = d[3]; m_ch = d[5]; m_dh = d[6]; end
            m_cnt = n_cnt; m_en = n_en; m_ip = n_ip;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 model count", cnt, m_cnt);
            chk("R12 model reload", rld, m_rld);
            chk("R1 model control", {25'd0, ctl},
                {25'd0, m_dh, m_ch, m_ip, m_ie, 1'b0, m_ar, m_en});
            chk("R4 model irq", {31'd0, irq}, {31'd0, m_irq});
        end
    end

    task automatic cyc(bit t, bit c, bit r, bit k, logic [31:0] v);
        @(negedge clk);
        tick = t; cw = c; rw = r; kw = k; d = v;
        @(posedge clk);
        #1;
        tick = 0; cw = 0; rw = 0; kw = 0; d = '0;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 count", cnt, 0);
        chk("R11 reload", rld, 0);
        chk("R11 control", {25'd0, ctl}, 0);
        chk("R11 irq", {31'd0, irq}, 0);
        rst_n = 1'b1;

        // R3 / R8: load 5, run with interrupt, expiry on tick 6
        cyc(0, 0, 1, 0, 32'd5);
        cyc(0, 1, 0, 0, 32'h0D);
        chk("R8 load copies reload", cnt, 5);
        chk("R8 load reads zero", {25'd0, ctl}, 32'h09);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(1, 0, 0, 0, 0);
            n++;
            if (irq) break;
        end
        chk("R3 ticks to expiry", n, 6);
        chk("R5 stopped, R4 pending", {25'd0, ctl}, 32'h18);
        chk("R5 count stays zero", cnt, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R4 irq single cycle", {31'd0, irq}, 0);

        // R6 pending write semantics
        cyc(0, 1, 0, 0, 32'h08);
        chk("R6 zero keeps pending", {25'd0, ctl}, 32'h18);
        cyc(0, 1, 0, 0, 32'h18);
        chk("R6 one clears pending", {25'd0, ctl}, 32'h08);

        // R5 auto-restart: reload 2 -> expiry every 3 ticks
        cyc(0, 0, 1, 0, 32'd2);
        cyc(0, 1, 0, 0, 32'h0F);
        n = 0;
        for (int i = 0; i < 9; i++) begin
            cyc(1, 0, 0, 0, 0);
            if (irq) n++;
        end
        chk("R5 restart expiries", n, 3);
        chk("R5 restart count", cnt, 2);

        // R7 expiry and clear in one cycle
        cyc(0, 0, 0, 1, 32'd0);
        cyc(1, 1, 0, 0, 32'h1B);
        chk("R7 set wins", {25'd0, ctl}, 32'h1B);
        chk("R7 irq", {31'd0, irq}, 1);
        chk("R7 reloaded", cnt, 2);

        // R9 count write beats tick and expiry
        cyc(1, 0, 0, 1, 32'd100);
        chk("R9 write over tick", cnt, 100);
        cyc(0, 0, 0, 1, 32'd0);
        cyc(1, 0, 0, 1, 32'd7);
        chk("R9 no expiry irq", {31'd0, irq}, 0);
        chk("R9 new count", cnt, 7);

        // R10 chain/halt stored, inert; R12 reload write leaves count
        cyc(0, 1, 0, 0, 32'h61);
        chk("R10 readback", {25'd0, ctl}, 32'h71);
        cyc(1, 0, 1, 0, 32'd50);
        chk("R12 reload write count", cnt, 6);
        chk("R12 reload stored", rld, 50);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R10 counts normally", cnt, 4);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int s;
            s = $urandom % 10;
            cyc(($urandom % 3) != 0, s == 0, s == 1, s == 2,
                (s == 0) ? ($urandom % 128) : ($urandom % 6));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule